// File: doc/BRIEF.md
# PCI Target Termination Controller

This block sits on the target side of a PCI interface and chooses how each claimed transaction ends. At the address phase it samples the command direction, the two low address bits, the decode hits for local memory and for the boot-ROM range, and a set of internal busy flags. It then either claims the cycle for data transfer, asks the initiator to retry, or aborts. During data phases it paces TRDY from a local data-ready strobe. It ends bursts at cache-line boundaries according to the burst ordering, and it guards against a slow local memory with two watchdog windows.

The three bus outputs are active low and registered. After any STOP the block holds its outputs until the initiator drops FRAME, then releases them all on the next clock.

Top module: `pci_term_top`

## Requirements
- R1: While reset is asserted and after it is released with no transaction, trdyN, stopN and devselN are all high.
- R2: A write that hits the ROM range is target-aborted: on the cycle after the address phase, stopN is low, devselN is high and trdyN is high. A read of the ROM range is claimed normally.
- R3: The block signals retry on the cycle after the address phase (stopN low, devselN low, trdyN high) when any of these holds: copyback busy, config-write busy, register access busy, a local-memory write while the write buffers are full, or a local-memory access without the exclusive flag while the device is locked. Otherwise a claimed access shows devselN low with stopN and trdyN high.
- R4: Abort wins over retry, and retry wins over any line-end or reserved-ordering disconnect.
- R5: If no data beat has been offered within 16 clocks of the address phase, stopN falls with trdyN high and devselN low, on the 17th sampling point after the address phase.
- R6: After at least one beat has completed, 8 clocks without trdyN low end the transaction with a disconnect without data (stopN low, trdyN high, devselN low).
- R7: With adLow = 2'b10 (wrap ordering), a read is stopped with data on its eighth beat, so one 32-byte line moves.
- R8: With wrap ordering, a write is stopped with data on its first beat.
- R9: With adLow = 2'b00 (linear ordering), stopN is asserted together with the beat whose line position (lineOffset plus beats done, modulo 8) is 7.
- R10: With adLow[0] = 1 (reserved ordering), the first beat carries STOP.
- R11: When a beat carrying STOP completes while FRAME is still asserted, trdyN goes high on the next clock while stopN and devselN stay low.
- R12: stopN stays low while frameN is low. On the clock after frameN is seen high, all three outputs are released.
- R13: An address phase that hits neither local memory nor ROM is ignored, and all outputs stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| frameN | input | 1 | Initiator FRAME, active low |
| irdyN | input | 1 | Initiator ready, active low |
| isWrite | input | 1 | Command is a write (address phase) |
| adLow | input | 2 | AD[1:0] at the address phase: burst ordering |
| lineOffset | input | POS_W (3) | Starting beat position in the cache line |
| localHit | input | 1 | Address decodes to local memory |
| romHit | input | 1 | Address decodes to the ROM range |
| exclusiveAcc | input | 1 | Access is an exclusive (locked) access |
| copybackBusy | input | 1 | Processor copyback in progress |
| wrBufFull | input | 1 | Local-memory write buffers full |
| devLocked | input | 1 | Device is locked by an initiator |
| cfgWrBusy | input | 1 | Serialized config write pending |
| regBusy | input | 1 | Internal register access in progress |
| dataReady | input | 1 | Local memory can supply or accept a beat |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Target stop, active low |
| devselN | output | 1 | Device select, active low |

## Verification
The bench builds the block with its default parameters: a 32-byte line of eight 4-byte beats, a 16-clock first-beat window and an 8-clock later-beat window. These sizes make both watchdog expiries reachable in a few dozen clocks. They also let a wrap read run to the full line end and a linear burst start mid-line and stop after three beats. A vector table covers each address-phase decision and the priority ties, and directed bursts cover the line-end rules and the shapes of the disconnects.

// File: rtl/pci_term_pkg.sv
`timescale 1ns/1ps
package pci_term_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_TERM
  } tgtState_t;

  typedef enum logic [1:0] {
    MODE_LINEAR,
    MODE_WRAP,
    MODE_RESERVED
  } burstMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture address-phase attributes
    logic clrWait;  // restart the wait window
    logic incWait;  // one more clock without a beat offered
    logic advBeat;  // a beat completed, move to the next
  } dpStrobe_t;

endpackage

// File: rtl/pci_term_dp.sv
`timescale 1ns/1ps
module pci_term_dp
  import pci_term_pkg::*;
#(
  parameter int LINE_BEATS  = 8,
  parameter int FIRST_LIMIT = 16,
  parameter int LATER_LIMIT = 8,
  localparam int POS_W = $clog2(LINE_BEATS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             isWrite,
  input  logic [1:0]       adLow,
  input  logic [POS_W-1:0] lineOffset,
  input  logic             localHit,
  input  logic             romHit,
  input  logic             exclusiveAcc,
  input  logic             copybackBusy,
  input  logic             wrBufFull,
  input  logic             devLocked,
  input  logic             cfgWrBusy,
  input  logic             regBusy,
  output logic             claim,
  output logic             abortReq,
  output logic             retryReq,
  output logic             lastCur,
  output logic             lastNext,
  output logic             waitExpired
);

  localparam int CNT_W  = POS_W + 1;
  localparam int MAXLIM = (FIRST_LIMIT > LATER_LIMIT) ? FIRST_LIMIT : LATER_LIMIT;
  localparam int WAIT_W = $clog2(MAXLIM) + 1;
  localparam logic [WAIT_W-1:0] FIRST_MAX = WAIT_W'(FIRST_LIMIT - 1);
  localparam logic [WAIT_W-1:0] LATER_MAX = WAIT_W'(LATER_LIMIT - 1);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(LINE_BEATS - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(LINE_BEATS - 1);

  burstMode_t         modeQ;
  logic               writeQ;
  logic [POS_W-1:0]   startPos;
  logic [CNT_W-1:0]   beatCnt;
  logic [WAIT_W-1:0]  waitCnt;
  burstMode_t         modeIn;

  always_comb begin
    case (adLow)
      2'b00:   modeIn = MODE_LINEAR;
      2'b10:   modeIn = MODE_WRAP;
      default: modeIn = MODE_RESERVED;
    endcase
  end

  // address-phase decisions
  assign claim    = localHit || romHit;
  assign abortReq = romHit && isWrite;
  assign retryReq = copybackBusy || cfgWrBusy || regBusy
                 || (localHit && isWrite && wrBufFull)
                 || (localHit && devLocked && !exclusiveAcc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_LINEAR;
      writeQ   <= 1'b0;
      startPos <= '0;
      beatCnt  <= '0;
      waitCnt  <= '0;
    end else begin
      if (strobe.latch) begin
        modeQ    <= modeIn;
        writeQ   <= isWrite;
        startPos <= lineOffset;
        beatCnt  <= '0;
      end else if (strobe.advBeat) begin
        beatCnt <= beatCnt + 1'b1;
      end
      if (strobe.clrWait)      waitCnt <= '0;
      else if (strobe.incWait) waitCnt <= waitCnt + 1'b1;
    end
  end

  function automatic logic lineEndAt(input logic [CNT_W-1:0] cnt);
    logic [POS_W-1:0] pos;
    pos = startPos + cnt[POS_W-1:0];
    case (modeQ)
      MODE_LINEAR: lineEndAt = (pos == LAST_POS);
      MODE_WRAP:   lineEndAt = writeQ || (cnt == LAST_CNT);
      default:     lineEndAt = 1'b1;
    endcase
  endfunction

  assign lastCur     = lineEndAt(beatCnt);
  assign lastNext    = lineEndAt(beatCnt + 1'b1);
  assign waitExpired = (beatCnt == '0) ? (waitCnt == FIRST_MAX) : (waitCnt == LATER_MAX);

  // R7: the beat index never runs past the end of one line
  a_r7_beat_in_line: assert property (@(posedge clk) disable iff (!rstN)
    beatCnt <= LAST_CNT);

  // R5/R6: the wait counter never passes the wider of the two windows
  a_r5_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= FIRST_MAX || waitCnt <= LATER_MAX);

endmodule

// File: rtl/pci_term_ctrl.sv
`timescale 1ns/1ps
module pci_term_ctrl
  import pci_term_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameN,
  input  logic      irdyN,
  input  logic      dataReady,
  input  logic      claim,
  input  logic      abortReq,
  input  logic      retryReq,
  input  logic      lastCur,
  input  logic      lastNext,
  input  logic      waitExpired,
  output dpStrobe_t strobe,
  output logic      trdyN,
  output logic      stopN,
  output logic      devselN
);

  tgtState_t state, stNext;
  logic trdyQ, stopQ, devQ;
  logic trdyD, stopD, devD;
  logic beatDone;

  assign beatDone = trdyQ && !irdyN;

  always_comb begin
    stNext = state;
    trdyD  = trdyQ;
    stopD  = stopQ;
    devD   = devQ;
    strobe = '0;
    case (state)
      ST_IDLE: begin
        if (!frameN && claim) begin
          strobe.latch   = 1'b1;
          strobe.clrWait = 1'b1;
          trdyD = 1'b0;
          devD  = !abortReq;
          stopD = abortReq || retryReq;
          stNext = (abortReq || retryReq) ? ST_TERM : ST_DATA;
        end
      end
      ST_DATA: begin
        if (beatDone) begin
          strobe.clrWait = 1'b1;
          if (frameN) begin
            stNext = ST_IDLE;
            trdyD = 1'b0; stopD = 1'b0; devD = 1'b0;
          end else if (stopQ) begin
            stNext = ST_TERM;
            trdyD  = 1'b0;
          end else begin
            strobe.advBeat = 1'b1;
            trdyD = dataReady;
            stopD = dataReady && lastNext;
          end
        end else if (!trdyQ) begin
          if (dataReady) begin
            trdyD = 1'b1;
            stopD = lastCur;
            strobe.clrWait = 1'b1;
          end else if (waitExpired) begin
            stopD  = 1'b1;
            stNext = ST_TERM;
          end else begin
            strobe.incWait = 1'b1;
          end
        end
      end
      default: begin
        if (frameN) begin
          stNext = ST_IDLE;
          trdyD = 1'b0; stopD = 1'b0; devD = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      trdyQ <= 1'b0;
      stopQ <= 1'b0;
      devQ  <= 1'b0;
    end else begin
      state <= stNext;
      trdyQ <= trdyD;
      stopQ <= stopD;
      devQ  <= devD;
    end
  end

  assign trdyN   = !trdyQ;
  assign stopN   = !stopQ;
  assign devselN = !devQ;

  // R2: an abort (STOP without DEVSEL) never offers data
  a_r2_abort_no_trdy: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && devselN) |-> trdyN);

  // R11: a completed STOP beat with FRAME still low drops TRDY next clock
  a_r11_trdy_drops: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !trdyN && !irdyN && !frameN) |=> (trdyN && !stopN));

  // R12: STOP is held while FRAME is asserted
  a_r12_stop_held: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !frameN) |=> !stopN);

  // R12: once FRAME is seen high under STOP, everything is released
  a_r12_release: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && frameN && (trdyN || !irdyN)) |=> (stopN && trdyN && devselN));

endmodule

// File: rtl/pci_term_top.sv
`timescale 1ns/1ps
module pci_term_top
  import pci_term_pkg::*;
#(
  parameter int LINE_BYTES  = 32,
  parameter int FIRST_LIMIT = 16,
  parameter int LATER_LIMIT = 8,
  localparam int LINE_BEATS = LINE_BYTES / 4,
  localparam int POS_W      = $clog2(LINE_BEATS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             isWrite,
  input  logic [1:0]       adLow,
  input  logic [POS_W-1:0] lineOffset,
  input  logic             localHit,
  input  logic             romHit,
  input  logic             exclusiveAcc,
  input  logic             copybackBusy,
  input  logic             wrBufFull,
  input  logic             devLocked,
  input  logic             cfgWrBusy,
  input  logic             regBusy,
  input  logic             dataReady,
  output logic             trdyN,
  output logic             stopN,
  output logic             devselN
);

  dpStrobe_t strobe;
  logic claim, abortReq, retryReq, lastCur, lastNext, waitExpired;

  pci_term_dp #(
    .LINE_BEATS (LINE_BEATS),
    .FIRST_LIMIT(FIRST_LIMIT),
    .LATER_LIMIT(LATER_LIMIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .isWrite(isWrite), .adLow(adLow), .lineOffset(lineOffset),
    .localHit(localHit), .romHit(romHit), .exclusiveAcc(exclusiveAcc),
    .copybackBusy(copybackBusy), .wrBufFull(wrBufFull), .devLocked(devLocked),
    .cfgWrBusy(cfgWrBusy), .regBusy(regBusy),
    .claim(claim), .abortReq(abortReq), .retryReq(retryReq),
    .lastCur(lastCur), .lastNext(lastNext), .waitExpired(waitExpired)
  );

  pci_term_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .dataReady(dataReady), .claim(claim), .abortReq(abortReq),
    .retryReq(retryReq), .lastCur(lastCur), .lastNext(lastNext),
    .waitExpired(waitExpired), .strobe(strobe),
    .trdyN(trdyN), .stopN(stopN), .devselN(devselN)
  );

endmodule

// File: tb/tb_pci_term_top.sv
`timescale 1ns/1ps
module tb_pci_term_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, irdyN = 1'b1, isWrite = 1'b0;
  logic [1:0] adLow = 2'b00;
  logic [2:0] lineOffset = 3'd0;
  logic localHit = 1'b0, romHit = 1'b0, exclusiveAcc = 1'b0;
  logic copybackBusy = 1'b0, wrBufFull = 1'b0, devLocked = 1'b0;
  logic cfgWrBusy = 1'b0, regBusy = 1'b0, dataReady = 1'b0;
  logic trdyN, stopN, devselN;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pci_term_top dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .isWrite(isWrite), .adLow(adLow), .lineOffset(lineOffset),
    .localHit(localHit), .romHit(romHit), .exclusiveAcc(exclusiveAcc),
    .copybackBusy(copybackBusy), .wrBufFull(wrBufFull), .devLocked(devLocked),
    .cfgWrBusy(cfgWrBusy), .regBusy(regBusy), .dataReady(dataReady),
    .trdyN(trdyN), .stopN(stopN), .devselN(devselN)
  );

  // vector: {wr,rom,loc,cb,wbf,lck,exc,cfg,reg,ad[1:0]} -> expected {stopN,devselN,trdyN}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    14'b0_0_1_0_0_0_0_0_0_00_101, // R3 plain local read claimed
    14'b1_0_1_0_0_0_0_0_0_00_101, // R3 plain local write claimed
    14'b0_0_1_1_0_0_0_0_0_00_001, // R3 copyback busy
    14'b1_0_1_0_1_0_0_0_0_00_001, // R3 write with buffers full
    14'b0_0_1_0_1_0_0_0_0_00_101, // R3 read ignores full buffers
    14'b0_0_1_0_0_1_0_0_0_00_001, // R3 locked, non-exclusive
    14'b0_0_1_0_0_1_1_0_0_00_101, // R3 locked, exclusive passes
    14'b0_0_1_0_0_0_0_1_0_00_001, // R3 config write pending
    14'b0_0_1_0_0_0_0_0_1_00_001, // R3 register access busy
    14'b1_1_0_0_0_0_0_0_0_00_011, // R2 ROM write aborted
    14'b0_1_0_0_0_0_0_0_0_00_101, // R2 ROM read claimed
    14'b1_1_0_1_0_0_0_0_0_00_011, // R4 abort beats retry
    14'b0_0_1_0_0_0_0_0_1_01_001, // R4 retry beats reserved-ordering disconnect
    14'b0_0_0_1_0_0_0_0_0_00_111  // R13 no hit ignored
  };
  localparam int VREQ [NV] = '{3,3,3,3,3,3,3,3,3,2,2,4,4,13};

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {stopN,devselN,trdyN} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleBus();
    frameN = 1'b1; irdyN = 1'b1; isWrite = 1'b0; adLow = 2'b00; lineOffset = 3'd0;
    localHit = 1'b0; romHit = 1'b0; exclusiveAcc = 1'b0; copybackBusy = 1'b0;
    wrBufFull = 1'b0; devLocked = 1'b0; cfgWrBusy = 1'b0; regBusy = 1'b0; dataReady = 1'b0;
  endtask

  // end the current transaction as an initiator and wait for release
  task automatic finishTxn();
    frameN = 1'b1; irdyN = 1'b0; dataReady = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (stopN && trdyN && devselN) break;
    end
    idleBus();
    @(negedge clk);
  endtask

  // run a burst with data always ready; FRAME drops as soon as STOP is seen
  task automatic burst(input logic wr, input logic [1:0] ad, input logic [2:0] off,
                       output int beats, output int stopBeat);
    isWrite = wr; adLow = ad; lineOffset = off; localHit = 1'b1;
    frameN = 1'b0; irdyN = 1'b0; dataReady = 1'b1;
    beats = 0; stopBeat = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i > 0 && stopN && trdyN && devselN) break;
      if (!trdyN && !irdyN) begin
        beats++;
        if (!stopN && stopBeat == 0) stopBeat = beats;
      end
      if (!stopN) frameN = 1'b1;
    end
    idleBus();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int beats, stopBeat, k;
    idleBus();
    repeat (2) @(negedge clk);
    chk("R1 in reset", {stopN, devselN, trdyN}, 3'b111);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after reset", {stopN, devselN, trdyN}, 3'b111);

    // address-phase decision table
    for (int v = 0; v < NV; v++) begin
      {isWrite, romHit, localHit, copybackBusy, wrBufFull, devLocked,
       exclusiveAcc, cfgWrBusy, regBusy, adLow} = VEC[v][13:3];
      frameN = 1'b0; irdyN = 1'b0; dataReady = 1'b0;
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VREQ[v], v), {stopN, devselN, trdyN}, VEC[v][2:0]);
      if (!stopN) begin
        frameN = 1'b1;
        @(negedge clk);
        chk($sformatf("R12 release vector %0d", v), {stopN, devselN, trdyN}, 3'b111);
      end
      finishTxn();
    end

    // R7: wrap read from mid-line moves a full line
    burst(1'b0, 2'b10, 3'd3, beats, stopBeat);
    chkInt("R7 wrap read beats", beats, 8);
    chkInt("R7 wrap read stop beat", stopBeat, 8);
    // R8: wrap write stops on first beat
    burst(1'b1, 2'b10, 3'd5, beats, stopBeat);
    chkInt("R8 wrap write beats", beats, 1);
    chkInt("R8 wrap write stop beat", stopBeat, 1);
    // R9: linear from position 5 stops at position 7
    burst(1'b0, 2'b00, 3'd5, beats, stopBeat);
    chkInt("R9 linear off5 beats", beats, 3);
    chkInt("R9 linear off5 stop beat", stopBeat, 3);
    burst(1'b1, 2'b00, 3'd0, beats, stopBeat);
    chkInt("R9 linear off0 stop beat", stopBeat, 8);
    // R10: reserved orderings stop on the first beat
    burst(1'b0, 2'b01, 3'd0, beats, stopBeat);
    chkInt("R10 ad=01 stop beat", stopBeat, 1);
    burst(1'b0, 2'b11, 3'd2, beats, stopBeat);
    chkInt("R10 ad=11 beats", beats, 1);

    // R11 / R12: disconnect-with-data shape with FRAME held
    isWrite = 1'b1; adLow = 2'b10; localHit = 1'b1;
    frameN = 1'b0; irdyN = 1'b0; dataReady = 1'b1;
    @(negedge clk);
    chk("R8 claim shape", {stopN, devselN, trdyN}, 3'b101);
    @(negedge clk);
    chk("R8 stop with data", {stopN, devselN, trdyN}, 3'b000);
    @(negedge clk);
    chk("R11 trdy dropped", {stopN, devselN, trdyN}, 3'b001);
    @(negedge clk);
    chk("R12 stop held", {stopN, devselN, trdyN}, 3'b001);
    frameN = 1'b1;
    @(negedge clk);
    chk("R12 released", {stopN, devselN, trdyN}, 3'b111);
    idleBus();
    @(negedge clk);

    // R5: first-beat window expires
    localHit = 1'b1; frameN = 1'b0; irdyN = 1'b0; dataReady = 1'b0;
    k = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (!stopN) begin k = i; break; end
    end
    chkInt("R5 retry sampling point", k, 17);
    chk("R5 retry shape", {stopN, devselN, trdyN}, 3'b001);
    finishTxn();

    // R6: later-beat window expires
    localHit = 1'b1; frameN = 1'b0; irdyN = 1'b0; dataReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 first beat offered", {stopN, devselN, trdyN}, 3'b100);
    dataReady = 1'b0;
    k = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (!stopN) begin k = i; break; end
    end
    chkInt("R6 disconnect sampling point", k, 9);
    chk("R6 disconnect without data", {stopN, devselN, trdyN}, 3'b001);
    finishTxn();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule